// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the 8-bit datapath of a small accumulator machine. One operand is always the accumulator. The other comes from an 8-bit operand port. An operation selected by a 4-bit code is applied on a clock edge where the strobe is high. The result goes back into the accumulator, and the condition flags are updated to match.

The operation set covers the following:
- binary add and subtract, each with a variant that also takes in the carry or borrow;
- compare, which only touches the flags;
- the three bitwise logic operations;
- single-bit rotates;
- ones' complement;
- a decimal-adjust step.

Two packed-BCD bytes summed in binary become a correct packed-BCD result after one decimal-adjust step. This needs a carry out of bit 3 that is kept alongside the usual carry out of bit 7.

Instruction decode, a register file, memory and multiply/divide live elsewhere. The surrounding sequencer only presents an opcode, an operand and a strobe.

Top module: `bcd_acc_alu`

## Requirements
- R1: A synchronous reset sets the accumulator and all flag bits to zero. No strobe is needed for this.
- R2: The accumulator and flags change only on a clock edge with `stb` high. Opcode values 12 to 15 leave both unchanged. The opcode codes are: ADD=0, ADC=1, SUB=2, SBB=3, AND=4, OR=5, XOR=6, CMP=7, ROL=8, ROR=9, CMA=10, DAA=11.
- R3: ADD loads acc+operand, and ADC loads acc+operand+CY. CY is the carry out of bit 7, and AC is the carry out of bit 3.
- R4: SUB loads acc-operand, and SBB loads acc-operand-CY. CY is set when the full subtraction borrows. AC is set when the low nibble borrows.
- R5: CMP sets every flag exactly as SUB would, and the accumulator keeps its value.
- R6: AND clears CY and sets AC. OR and XOR clear both CY and AC.
- R7: After ADD, ADC, SUB, SBB, CMP, AND, OR, XOR and DAA, three flags follow the 8-bit result. S is result bit 7. Z is set when the result is 0x00. With `PARITY_EVEN`=1, P is set when the result has an even number of ones. The flag byte places S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0, and its other bits read 0.
- R8: ROL shifts the accumulator left one place and ROR shifts it right one place. In the default circular variant (`ROT_THRU_CARRY`=0), the bit that leaves the accumulator re-enters at the far end and is also copied into CY. S, Z, AC and P keep their values.
- R9: CMA loads the bitwise inverse of the accumulator and leaves all flags unchanged.
- R10: DAA adds 6 to the accumulator when its low nibble exceeds 9 or AC is set. AC then becomes the carry out of bit 3 of that correction, or 0 when no correction is made.
- R11: After the low-nibble step, DAA adds 0x60 when the high nibble exceeds 9, when the low step carried out of bit 7, or when CY is set. CY is set if this correction is applied, and a CY that was already set stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stb | input | 1 | Execute the operation presented this cycle |
| op | input | 4 | Operation code (see R2) |
| opnd | input | 8 | Second operand |
| acc | output | 8 | Accumulator contents |
| flags | output | 8 | Flag byte: S[7] Z[6] AC[4] P[2] CY[0] |

## Verification
The bench builds the block with its defaults: even-parity flag sense and circular rotates. With these settings the parity of every result can be checked against the R7 encoding, and both rotate directions can be checked in their wrap-around form. Rotation through carry is reached only with `ROT_THRU_CARRY`=1, which this bench does not build.

The accumulator can only be preset through the datapath. Each case therefore starts from a reset followed by an ADD, which leaves CY and AC clear. Cases that need a set carry chain two arithmetic steps, as in multi-byte and BCD sums. The decimal-adjust cases cover three situations: correction driven only by AC, correction driven by a carry from a 99+99 sum, and double correction of an out-of-range byte.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int ACC_W   = 8;
   localparam int NIB_W   = 4;
   localparam int NIB_N   = ACC_W / NIB_W;
   localparam int FLAG_W  = 8;

   // bit positions inside the flag byte
   localparam int FB_CY   = 0;
   localparam int FB_P    = 2;
   localparam int FB_AC   = 4;
   localparam int FB_Z    = 6;
   localparam int FB_S    = 7;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBB = 4'd3,
      OP_AND = 4'd4,
      OP_OR  = 4'd5,
      OP_XOR = 4'd6,
      OP_CMP = 4'd7,
      OP_ROL = 4'd8,
      OP_ROR = 4'd9,
      OP_CMA = 4'd10,
      OP_DAA = 4'd11
   } alu_op_e;

   typedef struct packed {
      logic s;
      logic z;
      logic ac;
      logic p;
      logic cy;
   } alu_flags_t;

   function automatic logic [FLAG_W-1:0] flags_to_byte(input alu_flags_t f);
      logic [FLAG_W-1:0] b;
      b        = '0;
      b[FB_S]  = f.s;
      b[FB_Z]  = f.z;
      b[FB_AC] = f.ac;
      b[FB_P]  = f.p;
      b[FB_CY] = f.cy;
      return b;
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W  = 8,
   parameter int NW = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         half_c,
   output logic         full_c
);
   localparam int NN = W / NW;

   generate
      if ((W % NW) != 0 || NN < 2) begin : g_bad_width
         $error("alu_addsub: W must be a multiple of NW with at least two nibbles");
      end
   endgenerate

   logic [W-1:0] b_eff;
   logic [NN:0]  chain;

   assign b_eff    = sub ? ~b : b;
   // for subtraction the incoming borrow becomes an inverted carry
   assign chain[0] = cin ^ sub;

   generate
      for (genvar g = 0; g < NN; g++) begin : g_nib
         logic [NW:0] part;
         assign part = {1'b0, a[g*NW +: NW]} + {1'b0, b_eff[g*NW +: NW]}
                     + {{NW{1'b0}}, chain[g]};
         assign sum[g*NW +: NW] = part[NW-1:0];
         assign chain[g+1]      = part[NW];
      end
   endgenerate

   // carries out become borrows when subtracting
   assign half_c = chain[1]  ^ sub;
   assign full_c = chain[NN] ^ sub;

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter bit ROT_THRU_CARRY = 1'b0
) (
   input  alu_op_e          op,
   input  logic [ACC_W-1:0] a,
   input  logic [ACC_W-1:0] b,
   input  logic             cy_in,
   output logic [ACC_W-1:0] res,
   output logic             cy_out
);
   logic lfill;
   logic rfill;

   generate
      if (ROT_THRU_CARRY) begin : g_rot_carry
         assign lfill = cy_in;
         assign rfill = cy_in;
      end else begin : g_rot_circ
         assign lfill = a[ACC_W-1];
         assign rfill = a[0];
      end
   endgenerate

   always_comb begin
      res    = a;
      cy_out = cy_in;
      unique case (op)
         OP_AND: begin res = a & b; cy_out = 1'b0; end
         OP_OR:  begin res = a | b; cy_out = 1'b0; end
         OP_XOR: begin res = a ^ b; cy_out = 1'b0; end
         OP_ROL: begin res = {a[ACC_W-2:0], lfill}; cy_out = a[ACC_W-1]; end
         OP_ROR: begin res = {rfill, a[ACC_W-1:1]}; cy_out = a[0]; end
         OP_CMA: begin res = ~a; end
         default: ;
      endcase
   end

endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
   import alu_pkg::*;
(
   input  logic [ACC_W-1:0] a,
   input  logic             ac_in,
   input  logic             cy_in,
   output logic [ACC_W-1:0] res,
   output logic             ac_out,
   output logic             cy_out
);
   localparam int            DIG_MAX = 9;
   localparam int            FIX     = (1 << NIB_W) - 10;
   localparam logic [ACC_W:0] FIX_LO = (ACC_W+1)'(FIX);
   localparam logic [ACC_W-1:0] FIX_HI = ACC_W'(FIX) << (ACC_W - NIB_W);

   logic             lo_fix;
   logic             hi_fix;
   logic [NIB_W:0]   lo_nib;
   logic [ACC_W:0]   stage1;

   assign lo_fix = (a[NIB_W-1:0] > NIB_W'(DIG_MAX)) | ac_in;
   assign lo_nib = {1'b0, a[NIB_W-1:0]} + (lo_fix ? (NIB_W+1)'(FIX) : '0);
   assign stage1 = {1'b0, a} + (lo_fix ? FIX_LO : '0);

   assign hi_fix = cy_in | stage1[ACC_W]
                 | (stage1[ACC_W-1 -: NIB_W] > NIB_W'(DIG_MAX));

   assign res    = stage1[ACC_W-1:0] + (hi_fix ? FIX_HI : '0);
   assign ac_out = lo_nib[NIB_W];
   assign cy_out = hi_fix;

endmodule

// File: rtl/bcd_acc_alu.sv
module bcd_acc_alu
   import alu_pkg::*;
#(
   parameter bit PARITY_EVEN    = 1'b1,
   parameter bit ROT_THRU_CARRY = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stb,
   input  logic [3:0]        op,
   input  logic [ACC_W-1:0]  opnd,
   output logic [ACC_W-1:0]  acc,
   output logic [FLAG_W-1:0] flags
);
   generate
      if (ACC_W != NIB_N * NIB_W || NIB_N != 2) begin : g_bad_cfg
         $error("bcd_acc_alu: decimal adjust needs a two-digit accumulator");
      end
   endgenerate

   alu_op_e          op_e;
   logic [ACC_W-1:0] acc_q, acc_d;
   alu_flags_t       flag_q, flag_d;

   assign op_e = alu_op_e'(op);

   // arithmetic path
   logic             is_sub, use_cy;
   logic [ACC_W-1:0] ar_sum;
   logic             ar_half, ar_full;

   assign is_sub = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP);
   assign use_cy = (op_e == OP_ADC) || (op_e == OP_SBB);

   alu_addsub #(.W(ACC_W), .NW(NIB_W)) u_addsub (
      .a      (acc_q),
      .b      (opnd),
      .cin    (use_cy & flag_q.cy),
      .sub    (is_sub),
      .sum    (ar_sum),
      .half_c (ar_half),
      .full_c (ar_full)
   );

   // logic, rotate and complement path
   logic [ACC_W-1:0] lg_res;
   logic             lg_cy;

   alu_logic #(.ROT_THRU_CARRY(ROT_THRU_CARRY)) u_logic (
      .op     (op_e),
      .a      (acc_q),
      .b      (opnd),
      .cy_in  (flag_q.cy),
      .res    (lg_res),
      .cy_out (lg_cy)
   );

   // decimal adjust path
   logic [ACC_W-1:0] da_res;
   logic             da_ac, da_cy;

   alu_decadj u_decadj (
      .a      (acc_q),
      .ac_in  (flag_q.ac),
      .cy_in  (flag_q.cy),
      .res    (da_res),
      .ac_out (da_ac),
      .cy_out (da_cy)
   );

   function automatic alu_flags_t result_flags(input logic [ACC_W-1:0] r,
                                               input logic ac, input logic cy);
      alu_flags_t f;
      f.s  = r[ACC_W-1];
      f.z  = (r == '0);
      f.p  = PARITY_EVEN ? ~^r : ^r;
      f.ac = ac;
      f.cy = cy;
      return f;
   endfunction

   always_comb begin
      acc_d  = acc_q;
      flag_d = flag_q;
      if (stb) begin
         unique case (op_e)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
               acc_d  = ar_sum;
               flag_d = result_flags(ar_sum, ar_half, ar_full);
            end
            OP_CMP: begin
               flag_d = result_flags(ar_sum, ar_half, ar_full);
            end
            OP_AND: begin
               acc_d  = lg_res;
               flag_d = result_flags(lg_res, 1'b1, lg_cy);
            end
            OP_OR, OP_XOR: begin
               acc_d  = lg_res;
               flag_d = result_flags(lg_res, 1'b0, lg_cy);
            end
            OP_ROL, OP_ROR: begin
               acc_d     = lg_res;
               flag_d.cy = lg_cy;
            end
            OP_CMA: begin
               acc_d = lg_res;
            end
            OP_DAA: begin
               acc_d  = da_res;
               flag_d = result_flags(da_res, da_ac, da_cy);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         flag_q <= '0;
      end else begin
         acc_q  <= acc_d;
         flag_q <= flag_d;
      end
   end

   assign acc   = acc_q;
   assign flags = flags_to_byte(flag_q);

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (acc == '0 && flags == '0));                                      // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !stb |=> ($stable(acc) && $stable(flags)));                               // R2
   AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
      (stb && op == 4'd7) |=> (acc == $past(acc)));                             // R5
   AST_LOGIC_CLEARS_CY: assert property (@(posedge clk) disable iff (rst)
      (stb && (op == 4'd4 || op == 4'd5 || op == 4'd6)) |=> !flags[FB_CY]);     // R6
   AST_CMA_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
      (stb && op == 4'd10) |=> $stable(flags));                                 // R9
   AST_DAA_CY_STICKY: assert property (@(posedge clk) disable iff (rst)
      (stb && op == 4'd11 && flags[FB_CY]) |=> flags[FB_CY]);                   // R11
   AST_ROT_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst)
      (stb && (op == 4'd8 || op == 4'd9)) |=>
      (flags[FB_S] == $past(flags[FB_S]) && flags[FB_Z] == $past(flags[FB_Z])
       && flags[FB_AC] == $past(flags[FB_AC]) && flags[FB_P] == $past(flags[FB_P]))); // R8

endmodule

// File: tb/tb_bcd_acc_alu.sv
`timescale 1ns/1ps
module tb_bcd_acc_alu;

   logic       clk = 1'b0;
   logic       rst = 1'b0;
   logic       stb = 1'b0;
   logic [3:0] op  = 4'd0;
   logic [7:0] opnd = 8'd0;
   logic [7:0] acc;
   logic [7:0] flags;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2 clk = ~clk;

   bcd_acc_alu dut (
      .clk(clk), .rst(rst), .stb(stb), .op(op), .opnd(opnd),
      .acc(acc), .flags(flags)
   );

   typedef struct packed {
      logic [7:0] init;
      logic [3:0] op;
      logic [7:0] opnd;
      logic [7:0] e_acc;
      logic [7:0] e_flg;
   } vec_t;

   localparam int NV = 13;
   // flag byte: S=0x80 Z=0x40 AC=0x10 P=0x04 CY=0x01
   localparam vec_t VEC [NV] = '{
      '{8'h3A, 4'd0,  8'h46, 8'h80, 8'h90},  // R3 add, nibble carry
      '{8'hF0, 4'd0,  8'h10, 8'h00, 8'h45},  // R7 zero result with carry
      '{8'h05, 4'd2,  8'h07, 8'hFE, 8'h91},  // R4 subtract with borrow
      '{8'h55, 4'd7,  8'h55, 8'h55, 8'h44},  // R5 compare equal
      '{8'h0F, 4'd4,  8'hF5, 8'h05, 8'h14},  // R6 and
      '{8'h0F, 4'd5,  8'hF0, 8'hFF, 8'h84},  // R6 or
      '{8'hAA, 4'd6,  8'hAA, 8'h00, 8'h44},  // R7 xor to zero
      '{8'h81, 4'd8,  8'h00, 8'h03, 8'h85},  // R8 rotate left
      '{8'h01, 4'd9,  8'h00, 8'h80, 8'h01},  // R8 rotate right
      '{8'h3C, 4'd10, 8'h00, 8'hC3, 8'h04},  // R9 complement
      '{8'h9B, 4'd11, 8'h00, 8'h01, 8'h11},  // R11 both corrections
      '{8'h42, 4'd3,  8'h02, 8'h40, 8'h00},  // R4 sbb with clear carry
      '{8'h12, 4'd11, 8'h00, 8'h12, 8'h04}   // R10 no correction
   };
   localparam string TAG [NV] = '{"R3", "R7", "R4", "R5", "R6", "R6", "R7",
                                  "R8", "R8", "R9", "R11", "R4", "R10"};

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; stb = 1'b0;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic apply(input logic [3:0] o, input logic [7:0] d);
      @(negedge clk);
      op = o; opnd = d; stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
   endtask

   task automatic check(input string req, input logic [7:0] ea, input logic [7:0] ef);
      n_chk++;
      if (acc !== ea || flags !== ef) begin
         n_fail++;
         $display("FAIL %s acc=%02h flags=%02h expected acc=%02h flags=%02h",
                  req, acc, flags, ea, ef);
      end
   endtask

   initial begin
      do_reset();
      check("R1", 8'h00, 8'h00);

      for (int i = 0; i < NV; i++) begin
         do_reset();
         apply(4'd0, VEC[i].init);
         apply(VEC[i].op, VEC[i].opnd);
         check(TAG[i], VEC[i].e_acc, VEC[i].e_flg);
      end

      // R2: strobe low and undefined opcode leave state alone
      do_reset();
      apply(4'd0, 8'h5A);
      @(negedge clk);
      op = 4'd0; opnd = 8'h11; stb = 1'b0;
      @(negedge clk);
      check("R2", 8'h5A, 8'h04);
      apply(4'd15, 8'hFF);
      check("R2", 8'h5A, 8'h04);

      // R1: reset after activity
      do_reset();
      check("R1", 8'h00, 8'h00);

      // R3: add with carry in
      do_reset();
      apply(4'd0, 8'hFF);
      apply(4'd0, 8'h02);
      check("R3", 8'h01, 8'h11);
      apply(4'd1, 8'h10);
      check("R3", 8'h12, 8'h04);

      // R4: subtract with borrow in
      do_reset();
      apply(4'd2, 8'h01);
      check("R4", 8'hFF, 8'h95);
      apply(4'd3, 8'h0F);
      check("R4", 8'hEF, 8'h90);

      // R10: BCD 38+49, correction driven by AC only
      do_reset();
      apply(4'd0, 8'h38);
      apply(4'd0, 8'h49);
      apply(4'd11, 8'h00);
      check("R10", 8'h87, 8'h84);

      // R11: BCD 99+99, correction driven by CY, CY kept
      do_reset();
      apply(4'd0, 8'h99);
      apply(4'd0, 8'h99);
      apply(4'd11, 8'h00);
      check("R11", 8'h98, 8'h81);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule